// File: doc/BRIEF.md
# Dual-Slope Integrating Converter Sequencer

This block is the digital half of an integrating analog-to-digital converter. It drives three analog switch controls: the integrator short, the input connection and the opposite-polarity reference connection. It watches one comparator bit that reports whether the integrator output is still above zero. From these it measures how long the reference takes to discharge what the input charged.

A host pulses `start`. The block then shorts the integrator for a fixed number of ticks. It charges the integrator from the input for a fixed number of ticks, and the parameter for that count should be chosen to span whole mains periods. It then discharges the integrator with the reference, counting ticks until the comparator reports a zero crossing. The final count N gives the input as Vref × N / M, where M is the charge length. Every phase is timed in ticks of `tick_en`, a clock enable from an external prescaler. The capacitor value and the tick rate act the same way on charge and discharge, so the count depends only on the voltage ratio.

The counter has a plain binary mode. It also has an optional decimal clamp that limits a valid reading to 0..1999.

Top module: `dslope_adc_ctrl`

## Requirements
- R1: While `rst` is high and after it falls, the block is idle: all three switch outputs are 0, and `busy`, `done`, `result` and `over_range` are 0.
- R2: A `start` pulse seen while idle raises `busy` on the next clock and clears `result` and `over_range` to 0. A `start` seen while `busy` is 1 has no effect on timing or result.
- R3: Each conversion begins with `sw_zero` = 1 and the other two switches at 0, for exactly ZERO_TICKS ticks.
- R4: `sw_input` is 1 for exactly RUNUP_TICKS ticks per conversion, whatever the input level.
- R5: At most one switch output is 1 at any clock. A change from one active switch to another always passes through at least one tick with all three at 0.
- R6: `cmp_pos` = 1 means the integrator output is above zero. It passes through a two-flop synchronizer. N is the number of reference-phase ticks at which the synchronized bit is still 1, counted before the first tick at which it is 0. With a comparator that settles within a tick, N = ceil(M × Vin / Vref).
- R7: In binary mode, if the count reaches all ones (2^CNT_W − 1) before a crossing is seen, the conversion ends with `over_range` = 1 and `result` = all ones.
- R8: With DEC_CLAMP = 1, N ≤ 1999 is reported as is. Any N above 1999 ends with `over_range` = 1 and `result` = all ones.
- R9: `done` is a single-clock pulse in the cycle `busy` falls. `result` and `over_range` hold their values from then until the next accepted `start`.
- R10: For a fixed voltage ratio, the result does not change when the integrator slope or the tick period changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_en | input | 1 | Prescaled counting tick, one clock wide |
| start | input | 1 | Conversion request pulse |
| cmp_pos | input | 1 | Comparator: 1 = integrator output above zero (asynchronous) |
| sw_zero | output | 1 | Integrator short switch control |
| sw_input | output | 1 | Input connection switch control |
| sw_ref | output | 1 | Reference connection switch control |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-clock pulse when the result becomes valid |
| result | output | CNT_W | Discharge tick count N, all ones on over-range |
| over_range | output | 1 | Count exceeded the binary or decimal limit |

## Verification
The hardest states to reach are the edges of over-range. One is a crossing that lands on the very tick where the count meets its limit. The other is a crossing that lands one count short of it. Both depend on the analog ratio, not on any digital input. The bench places a behavioural integrator around two instances, one with a narrow binary counter and one with the decimal clamp. It picks input-to-reference ratios so that ceil(M × Vin / Vref) falls exactly on 254, 255, 1999 and 2000. It also sweeps a run of small inputs and repeats ratios with a different slope and tick period.

// File: rtl/dsadc_pkg.sv
package dsadc_pkg;

    typedef enum logic [2:0] {
        PH_IDLE     = 3'd0,
        PH_ZERO     = 3'd1,
        PH_GAP_A    = 3'd2,
        PH_RUNUP    = 3'd3,
        PH_GAP_B    = 3'd4,
        PH_RUNDOWN  = 3'd5
    } phase_e;

    typedef struct packed {
        logic zero;
        logic input_sel;
        logic ref_sel;
    } sw_t;

    function automatic sw_t phase_switches(phase_e ph);
        sw_t s;
        s.zero      = (ph == PH_ZERO);
        s.input_sel = (ph == PH_RUNUP);
        s.ref_sel   = (ph == PH_RUNDOWN);
        return s;
    endfunction

endpackage

// File: rtl/dsadc_sync.sv
module dsadc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = async_in;
        end else begin : g_multi
            always_comb chain_d = {chain_q[STAGES-2:0], async_in};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= chain_d;
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/dsadc_phase_timer.sv
module dsadc_phase_timer #(
    parameter int TMR_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [TMR_W-1:0] load_val,
    input  logic             tick_en,
    output logic             expired
);
    logic [TMR_W-1:0] remain_d, remain_q;

    always_comb begin
        remain_d = remain_q;
        if (load) begin
            remain_d = load_val;
        end else if (tick_en && (remain_q != '0)) begin
            remain_d = remain_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) remain_q <= '0;
        else     remain_q <= remain_d;
    end

    assign expired = (remain_q == '0);
endmodule

// File: rtl/dsadc_rundown_cnt.sv
module dsadc_rundown_cnt #(
    parameter int CNT_W     = 16,
    parameter bit DEC_CLAMP = 1'b0,
    parameter int DEC_LIMIT = 1999
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             step,
    output logic [CNT_W-1:0] count,
    output logic             at_limit
);
    logic [CNT_W-1:0] count_d, count_q;

    always_comb begin
        count_d = count_q;
        if (clear)     count_d = '0;
        else if (step) count_d = count_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) count_q <= '0;
        else     count_q <= count_d;
    end

    generate
        if (DEC_CLAMP) begin : g_decimal
            localparam logic [CNT_W-1:0] FIRST_BAD = CNT_W'(DEC_LIMIT + 1);
            assign at_limit = (count_q == FIRST_BAD);
        end else begin : g_binary
            assign at_limit = &count_q;
        end
    endgenerate

    assign count = count_q;
endmodule

// File: rtl/dslope_adc_ctrl.sv
module dslope_adc_ctrl
    import dsadc_pkg::*;
#(
    parameter int RUNUP_TICKS = 1000,
    parameter int ZERO_TICKS  = 16,
    parameter int CNT_W       = 16,
    parameter bit DEC_CLAMP   = 1'b0,
    parameter int DEC_LIMIT   = 1999,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    input  logic             start,
    input  logic             cmp_pos,
    output logic             sw_zero,
    output logic             sw_input,
    output logic             sw_ref,
    output logic             busy,
    output logic             done,
    output logic [CNT_W-1:0] result,
    output logic             over_range
);
    localparam int TMR_MAX = (RUNUP_TICKS > ZERO_TICKS) ? RUNUP_TICKS : ZERO_TICKS;
    localparam int TMR_W   = $clog2(TMR_MAX + 1);
    localparam logic [TMR_W-1:0] ZERO_LOAD  = TMR_W'(ZERO_TICKS - 1);
    localparam logic [TMR_W-1:0] RUNUP_LOAD = TMR_W'(RUNUP_TICKS - 1);

    typedef struct packed {
        phase_e           phase;
        sw_t              sw;
        logic             busy;
        logic             done;
        logic [CNT_W-1:0] result;
        logic             over;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    logic             cmp_sync;
    logic             tmr_load;
    logic [TMR_W-1:0] tmr_val;
    logic             tmr_expired;
    logic             cnt_clear;
    logic             cnt_step;
    logic [CNT_W-1:0] cnt_value;
    logic             cnt_at_limit;

    dsadc_sync #(
        .STAGES  (SYNC_STAGES)
    ) i_cmp_sync (
        .clk     (clk),
        .rst     (rst),
        .async_in(cmp_pos),
        .sync_out(cmp_sync)
    );

    dsadc_phase_timer #(
        .TMR_W   (TMR_W)
    ) i_phase_timer (
        .clk     (clk),
        .rst     (rst),
        .load    (tmr_load),
        .load_val(tmr_val),
        .tick_en (tick_en),
        .expired (tmr_expired)
    );

    dsadc_rundown_cnt #(
        .CNT_W    (CNT_W),
        .DEC_CLAMP(DEC_CLAMP),
        .DEC_LIMIT(DEC_LIMIT)
    ) i_rundown_cnt (
        .clk     (clk),
        .rst     (rst),
        .clear   (cnt_clear),
        .step    (cnt_step),
        .count   (cnt_value),
        .at_limit(cnt_at_limit)
    );

    // Sequencer: every phase advance happens on a tick, except leaving idle.
    always_comb begin
        ctrl_d      = ctrl_q;
        ctrl_d.done = 1'b0;
        tmr_load    = 1'b0;
        tmr_val     = '0;
        cnt_clear   = 1'b0;
        cnt_step    = 1'b0;

        unique case (ctrl_q.phase)
            PH_IDLE: begin
                if (start) begin
                    ctrl_d.phase  = PH_ZERO;
                    ctrl_d.busy   = 1'b1;
                    ctrl_d.result = '0;
                    ctrl_d.over   = 1'b0;
                    tmr_load      = 1'b1;
                    tmr_val       = ZERO_LOAD;
                end
            end
            PH_ZERO: begin
                if (tick_en && tmr_expired) ctrl_d.phase = PH_GAP_A;
            end
            PH_GAP_A: begin
                if (tick_en) begin
                    ctrl_d.phase = PH_RUNUP;
                    tmr_load     = 1'b1;
                    tmr_val      = RUNUP_LOAD;
                end
            end
            PH_RUNUP: begin
                if (tick_en && tmr_expired) ctrl_d.phase = PH_GAP_B;
            end
            PH_GAP_B: begin
                if (tick_en) begin
                    ctrl_d.phase = PH_RUNDOWN;
                    cnt_clear    = 1'b1;
                end
            end
            PH_RUNDOWN: begin
                if (tick_en) begin
                    if (cnt_at_limit) begin
                        ctrl_d.phase  = PH_IDLE;
                        ctrl_d.busy   = 1'b0;
                        ctrl_d.done   = 1'b1;
                        ctrl_d.over   = 1'b1;
                        ctrl_d.result = '1;
                    end else if (!cmp_sync) begin
                        ctrl_d.phase  = PH_IDLE;
                        ctrl_d.busy   = 1'b0;
                        ctrl_d.done   = 1'b1;
                        ctrl_d.result = cnt_value;
                    end else begin
                        cnt_step = 1'b1;
                    end
                end
            end
            default: begin
                ctrl_d.phase = PH_IDLE;
                ctrl_d.busy  = 1'b0;
            end
        endcase

        ctrl_d.sw = phase_switches(ctrl_d.phase);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q.phase  <= PH_IDLE;
            ctrl_q.sw     <= '0;
            ctrl_q.busy   <= 1'b0;
            ctrl_q.done   <= 1'b0;
            ctrl_q.result <= '0;
            ctrl_q.over   <= 1'b0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign sw_zero    = ctrl_q.sw.zero;
    assign sw_input   = ctrl_q.sw.input_sel;
    assign sw_ref     = ctrl_q.sw.ref_sel;
    assign busy       = ctrl_q.busy;
    assign done       = ctrl_q.done;
    assign result     = ctrl_q.result;
    assign over_range = ctrl_q.over;
endmodule

// File: rtl/dslope_adc_chk.sv
module dslope_adc_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             sw_zero,
    input logic             sw_input,
    input logic             sw_ref,
    input logic             busy,
    input logic             done,
    input logic [CNT_W-1:0] result,
    input logic             over_range
);
    logic [2:0] sw_vec;
    assign sw_vec = {sw_zero, sw_input, sw_ref};

    assert_idle_open_R1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (sw_vec == 3'b000));

    assert_start_taken_R2: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    assert_zero_first_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (sw_vec == 3'b100));

    assert_single_switch_R5: assert property (@(posedge clk) disable iff (rst)
        $countones(sw_vec) <= 1);

    assert_dead_tick_R5: assert property (@(posedge clk) disable iff (rst)
        ((|sw_vec) && $past(|sw_vec)) |-> (sw_vec == $past(sw_vec)));

    assert_over_ones_R7: assert property (@(posedge clk) disable iff (rst)
        over_range |-> (&result));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_at_end_R9: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));

    assert_result_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> ($stable(result) && $stable(over_range)));
endmodule

bind dslope_adc_ctrl dslope_adc_chk #(
    .CNT_W(CNT_W)
) i_dslope_adc_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .sw_zero   (sw_zero),
    .sw_input  (sw_input),
    .sw_ref    (sw_ref),
    .busy      (busy),
    .done      (done),
    .result    (result),
    .over_range(over_range)
);

// File: tb/test_dslope_adc_ctrl.sv
module test_integ_model (
    input  logic clk,
    input  logic tick,
    input  logic clr,
    input  logic sw_zero,
    input  logic sw_input,
    input  logic sw_ref,
    input  int   vin,
    input  int   vref,
    input  int   slope,
    output logic cmp_pos,
    output int   in_ticks,
    output int   zero_ticks
);
    int level = 0;
    initial begin
        in_ticks   = 0;
        zero_ticks = 0;
    end
    always @(posedge clk) begin
        if (clr) begin
            in_ticks   <= 0;
            zero_ticks <= 0;
        end else if (tick) begin
            if (sw_zero) begin
                level      <= 0;
                zero_ticks <= zero_ticks + 1;
            end else if (sw_input) begin
                level    <= level + vin * slope;
                in_ticks <= in_ticks + 1;
            end else if (sw_ref) begin
                level <= level - vref * slope;
            end
        end
    end
    assign cmp_pos = (level > 0);
endmodule

module test_dslope_adc_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int M_TICKS    = 20;
    localparam int Z_TICKS    = 3;
    localparam int BW         = 8;
    localparam int DW         = 12;
    localparam int BIN_MAX    = (1 << BW) - 1;
    localparam int DEC_MAX    = (1 << DW) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic tick = 1'b0;
    logic mdl_clr = 1'b0;
    int   tick_div = 4;
    int   div_cnt = 0;
    int   vin = 0, vref = 20, slope = 1;
    int   n_tests = 0, n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        if (div_cnt >= tick_div - 1) begin
            div_cnt <= 0;
            tick    <= 1'b1;
        end else begin
            div_cnt <= div_cnt + 1;
            tick    <= 1'b0;
        end
    end

    logic          zb, ib, rb, busy_b, done_b, ov_b, cmp_b;
    logic [BW-1:0] res_b;
    int            in_b, zt_b;
    logic          zd, id, rd, busy_d, done_d, ov_d, cmp_d;
    logic [DW-1:0] res_d;
    int            in_d, zt_d;

    dslope_adc_ctrl #(
        .RUNUP_TICKS(M_TICKS), .ZERO_TICKS(Z_TICKS), .CNT_W(BW),
        .DEC_CLAMP(1'b0), .DEC_LIMIT(1999), .SYNC_STAGES(2)
    ) i_dslope_adc_ctrl (
        .clk(clk), .rst(rst), .tick_en(tick), .start(start), .cmp_pos(cmp_b),
        .sw_zero(zb), .sw_input(ib), .sw_ref(rb), .busy(busy_b), .done(done_b),
        .result(res_b), .over_range(ov_b)
    );

    dslope_adc_ctrl #(
        .RUNUP_TICKS(M_TICKS), .ZERO_TICKS(Z_TICKS), .CNT_W(DW),
        .DEC_CLAMP(1'b1), .DEC_LIMIT(1999), .SYNC_STAGES(2)
    ) i_dslope_adc_ctrl_dec (
        .clk(clk), .rst(rst), .tick_en(tick), .start(start), .cmp_pos(cmp_d),
        .sw_zero(zd), .sw_input(id), .sw_ref(rd), .busy(busy_d), .done(done_d),
        .result(res_d), .over_range(ov_d)
    );

    test_integ_model i_mdl_b (
        .clk(clk), .tick(tick), .clr(mdl_clr), .sw_zero(zb), .sw_input(ib),
        .sw_ref(rb), .vin(vin), .vref(vref), .slope(slope), .cmp_pos(cmp_b),
        .in_ticks(in_b), .zero_ticks(zt_b)
    );

    test_integ_model i_mdl_d (
        .clk(clk), .tick(tick), .clr(mdl_clr), .sw_zero(zd), .sw_input(id),
        .sw_ref(rd), .vin(vin), .vref(vref), .slope(slope), .cmp_pos(cmp_d),
        .in_ticks(in_d), .zero_ticks(zt_d)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic conv(input int v, input int r, input int s, input int div,
                        input bit extra_start, input string req);
        int n_exp, eb, ed, nd_b, nd_d, cap_b, cap_d, guard;
        bit ob, od, cov_b, cov_d;
        vin = v; vref = r; slope = s; tick_div = div;
        n_exp = (M_TICKS * v + r - 1) / r;
        ob = (n_exp >= BIN_MAX);
        eb = ob ? BIN_MAX : n_exp;
        od = (n_exp > 1999);
        ed = od ? DEC_MAX : n_exp;
        @(negedge clk); mdl_clr = 1'b1;
        @(negedge clk); mdl_clr = 1'b0; start = 1'b1;
        @(negedge clk); start = 1'b0;
        // R2 / R3: busy and zeroing switch one clock after start
        chk(busy_b && busy_d, "R2", "busy after start", int'(busy_b && busy_d), 1);
        chk(zb && !ib && !rb, "R3", "zero switch first", int'({zb, ib, rb}), 4);
        chk(res_b == 0 && !ov_b, "R2", "result cleared on start", int'(res_b), 0);
        nd_b = 0; nd_d = 0; cap_b = 0; cap_d = 0; cov_b = 0; cov_d = 0; guard = 0;
        while ((busy_b || busy_d) && guard < 40000) begin
            @(negedge clk);
            guard++;
            start = (extra_start && guard == 10);
            if (done_b) begin nd_b++; cap_b = int'(res_b); cov_b = ov_b; end
            if (done_d) begin nd_d++; cap_d = int'(res_d); cov_d = ov_d; end
        end
        start = 1'b0;
        chk(nd_b == 1 && nd_d == 1, req, "done pulse count (R9)", nd_b + nd_d, 2);
        chk(cap_b == eb, req, "binary result (R6/R7)", cap_b, eb);
        chk(cov_b == ob, req, "binary over-range (R7)", int'(cov_b), int'(ob));
        chk(cap_d == ed, req, "decimal result (R8)", cap_d, ed);
        chk(cov_d == od, req, "decimal over-range (R8)", int'(cov_d), int'(od));
        chk(in_b == M_TICKS && in_d == M_TICKS, "R4", "input ticks", in_b, M_TICKS);
        chk(zt_b == Z_TICKS && zt_d == Z_TICKS, "R3", "zero ticks", zt_b, Z_TICKS);
        repeat (3) @(negedge clk);
        chk(int'(res_b) == cap_b && int'(res_d) == cap_d, "R9", "result held",
            int'(res_b), cap_b);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R1: values during reset
        chk(!zb && !ib && !rb && !busy_b && !done_b && res_b == 0 && !ov_b,
            "R1", "reset state", int'(res_b), 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk(!zd && !id && !rd && !busy_d && !done_d && res_d == 0 && !ov_d,
            "R1", "idle after reset", int'(res_d), 0);

        conv(0, 20, 1, 4, 1'b0, "R6");
        conv(7, 20, 1, 4, 1'b0, "R6");
        conv(13, 3, 1, 4, 1'b0, "R6");
        conv(254, 20, 1, 4, 1'b0, "R7");
        conv(255, 20, 1, 4, 1'b0, "R7");
        conv(1999, 20, 1, 4, 1'b0, "R8");
        conv(2000, 20, 1, 4, 1'b0, "R8");
        // R10: same ratios with other slopes and tick periods
        conv(13, 3, 7, 7, 1'b0, "R10");
        conv(254, 20, 3, 5, 1'b0, "R10");
        conv(1999, 20, 2, 3, 1'b0, "R10");
        // R2: extra start while busy is ignored
        conv(50, 20, 1, 4, 1'b1, "R2");
        // R6: sweep of small inputs against a fixed reference
        for (int v = 0; v <= 24; v++) conv(v, 7, 2, 4, 1'b0, "R6");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule